// File: doc/BRIEF.md
# SPI Slave Burst Receiver

This block is the receive half of an SPI slave that runs in mode 0. It brings SCLK, MOSI and the active-low select into the system clock domain and shifts bits in MSB first. It groups the bits into bursts of a programmable length and writes each finished burst into a small receive FIFO. A host reads that FIFO. Data stays hidden from the reading side until a burst has been committed.

A configuration write sets two things. The first is the burst length field, which holds N, so that one burst is N+1 bits. The second is a mode bit that decides what ends a burst. In select-terminated mode a burst is committed only when the master releases the select, and a burst that is short or too long is still stored. In count-terminated mode a burst is committed the moment its last bit is sampled, and several bursts can follow one another under a single select assertion. Every configuration write also clears the sticky overflow flag.

Top module: `spi_burst_rx`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0 and rx_ovf is 0.
- R2: With cfg_cnt_mode = 1 (count-terminated), every group of cfg_len+1 bits received under one select assertion is committed as a separate entry, MSB first and right-aligned. The entry is committed as soon as its last bit is sampled, without waiting for the select to be released.
- R3: With cfg_cnt_mode = 1, bits left over when the select is released (fewer than cfg_len+1) are discarded and produce no entry.
- R4: With cfg_cnt_mode = 0 (select-terminated), nothing is committed while spi_ss_n stays low, however many bits arrive.
- R5: With cfg_cnt_mode = 0, releasing the select commits the bits received, right-aligned with zero upper bits, even when fewer than cfg_len+1 arrived. A select pulse with no bits commits nothing.
- R6: With cfg_cnt_mode = 0, if more than cfg_len+1 bits arrive, only the last cfg_len+1 bits are kept.
- R7: While a burst is in progress and not yet committed, the FIFO shows no sign of it (rx_empty is unchanged).
- R8: The FIFO returns entries in commit order. rd_data shows the oldest entry while rx_empty is 0, and rd_en advances it. rd_en while the FIFO is empty has no effect.
- R9: rx_full is 1 when the FIFO holds 8 entries. A commit while full is dropped and sets rx_ovf, which stays set until the next cfg_we.
- R10: SCLK edges while spi_ss_n is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the master (mode 0) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| cfg_we | input | 1 | Configuration write strobe; also clears rx_ovf |
| cfg_len | input | 5 | Burst length minus one |
| cfg_cnt_mode | input | 1 | 1 = count-terminated, 0 = select-terminated |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 32 | Oldest FIFO entry |
| rx_empty | output | 1 | FIFO empty |
| rx_full | output | 1 | FIFO full |
| rx_ovf | output | 1 | Sticky overflow flag |

## Verification
An SCLK or select edge at a pin passes through two synchronizer flops and one edge-detect stage. The commit then lands in the FIFO one edge later, so a result appears three system clocks after the pin changes. The bench holds each SCLK level for four system clocks and waits eight clocks after releasing the select before it looks at the flags. In count-terminated mode it checks that committed bursts are visible before the select is released. In select-terminated mode it checks that nothing is visible before the release. A pop shows the next entry on rd_data one clock after rd_en, and the bench compares data one negative edge after each pop.

// File: rtl/spi_burst_rx.sv
module spi_burst_rx #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_mosi,
  input  logic                   spi_ss_n,
  input  logic                   cfg_we,
  input  logic [$clog2(DW)-1:0]  cfg_len,
  input  logic                   cfg_cnt_mode,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  output logic                   rx_empty,
  output logic                   rx_full,
  output logic                   rx_ovf
);
  localparam int LW = $clog2(DW);
  localparam int CW = LW + 1;
  localparam int AW = $clog2(DEPTH);

  logic [2:0] sclk_q, ss_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      ss_q   <= {ss_q[1:0], spi_ss_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire ss_act    = ~ss_q[1];
  wire ss_rel    = ss_q[1] & ~ss_q[2];
  wire bit_in    = mosi_q[1];

  logic [LW-1:0] len_q;
  logic          cnt_mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_q      <= LW'(7);
      cnt_mode_q <= 1'b0;
    end else if (cfg_we) begin
      len_q      <= cfg_len;
      cnt_mode_q <= cfg_cnt_mode;
    end

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  wire [DW-1:0] sh_next = {sh[DW-2:0], bit_in};
  wire [CW-1:0] len_p1  = {1'b0, len_q} + CW'(1);
  wire [DW:0]   mask_w  = ((DW+1)'(1) << len_p1) - (DW+1)'(1);
  wire [DW-1:0] mask    = mask_w[DW-1:0];

  wire cnt_hit  = sclk_rise & ss_act & cnt_mode_q & (cnt == {1'b0, len_q});
  wire push_ss  = ss_rel & ~cnt_mode_q & (cnt != '0);
  wire push     = cnt_hit | push_ss;
  wire [DW-1:0] push_data = (cnt_hit ? sh_next : sh) & mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (!ss_act) begin
      sh  <= '0;
      cnt <= '0;
    end else if (sclk_rise) begin
      if (cnt_hit) begin
        sh  <= '0;
        cnt <= '0;
      end else begin
        sh <= sh_next;
        if (cnt != CW'(DW)) cnt <= cnt + CW'(1);
      end
    end

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;

  assign rx_full  = (fill == (AW+1)'(DEPTH));
  assign rx_empty = (fill == '0);
  assign rd_data  = mem[rp];

  wire do_push = push & ~rx_full;
  wire do_pop  = rd_en & ~rx_empty;

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      fill   <= '0;
      rx_ovf <= 1'b0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + (AW+1)'(1);
        2'b01:   fill <= fill - (AW+1)'(1);
        default: fill <= fill;
      endcase
      if (push & rx_full) rx_ovf <= 1'b1;
      else if (cfg_we)    rx_ovf <= 1'b0;
    end
endmodule

// File: rtl/spi_burst_rx_chk.sv
module spi_burst_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic rd_en,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_ovf,
  input logic push,
  input logic ss_rel,
  input logic cnt_mode
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_empty && rx_full)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rx_ovf && !cfg_we |=> rx_ovf); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_ovf) |-> $past(rx_full)); // R9
  AST_NO_FALSE_FULL: assert property (@(posedge clk) disable iff (!rst_n) !rx_full && !push |=> !rx_full); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) rx_empty && rd_en && !push |=> rx_empty); // R8
  AST_SS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cnt_mode && !ss_rel && rx_empty |=> rx_empty); // R4
endmodule

bind spi_burst_rx spi_burst_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rd_en(rd_en),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
  .push(push), .ss_rel(ss_rel), .cnt_mode(cnt_mode_q)
);

// File: tb/spi_burst_rx_tb.sv
module spi_burst_rx_tb;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, ss_n = 1, cfg_we = 0, mode = 0, rd_en = 0;
  logic [4:0] len = 5'd7;
  logic [31:0] rd_data;
  logic rx_empty, rx_full, rx_ovf;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  bit exp_ovf = 0;

  always #5 clk = ~clk;

  spi_burst_rx u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_ss_n(ss_n),
    .cfg_we(cfg_we), .cfg_len(len), .cfg_cnt_mode(mode), .rd_en(rd_en),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int l, input bit m);
    @(negedge clk);
    len = 5'(l); mode = m; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    exp_ovf = 0;
  endtask

  task automatic model_push(input logic [31:0] v);
    if (exp_q.size() == 8) exp_ovf = 1;
    else exp_q.push_back(v);
  endtask

  function automatic logic [31:0] lmask(input int l);
    return (l == 31) ? 32'hffff_ffff : ((32'h1 << (l + 1)) - 1);
  endfunction

  task automatic model(input logic [63:0] v, input int n, input int l, input bit m);
    logic [63:0] acc = 0;
    int c = 0;
    for (int i = n - 1; i >= 0; i--) begin
      acc = {acc[62:0], v[i]};
      c++;
      if (m && c == l + 1) begin
        model_push(acc[31:0] & lmask(l));
        acc = 0; c = 0;
      end
    end
    if (!m && n > 0) model_push(acc[31:0] & lmask(l));
  endtask

  task automatic check_flags(input string tag);
    chk(rx_empty == (exp_q.size() == 0), {tag, " empty"}, 32'(rx_empty), 32'(exp_q.size() == 0));
    chk(rx_full == (exp_q.size() == 8), {tag, " full"}, 32'(rx_full), 32'(exp_q.size() == 8));
    chk(rx_ovf == exp_ovf, {tag, " ovf"}, 32'(rx_ovf), 32'(exp_ovf));
  endtask

  task automatic xfer(input logic [63:0] v, input int n);
    bit pre_empty;
    if (mode) model(v, n, int'(len), 1);
    pre_empty = (exp_q.size() == 0);
    @(negedge clk); ss_n = 0;
    clks(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      clks(4); sclk = 1;
      clks(4); sclk = 0;
    end
    clks(6);
    if (mode) chk(rx_empty == pre_empty, "R2 commit before release", 32'(rx_empty), 32'(pre_empty));
    else      chk(rx_empty == pre_empty, "R4 R7 hidden until release", 32'(rx_empty), 32'(pre_empty));
    ss_n = 1;
    if (!mode) model(v, n, int'(len), 0);
    clks(8);
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 12 && !rx_empty; k++) begin
      logic [31:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hdead_beef;
      chk(rd_data == e, {tag, " R8 data"}, rd_data, e);
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      @(negedge clk);
    end
    chk(rx_empty && exp_q.size() == 0, {tag, " R8 drained"}, 32'(rx_empty), 32'(exp_q.size()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clks(3);
    check_flags("R1 reset");
    rst_n = 1;
    clks(2);
    check_flags("R1 after reset");

    // R10: SCLK edges with select high, one-bit bursts would push if seen
    cfg(0, 1);
    for (int i = 0; i < 10; i++) begin
      mosi = i[0]; clks(4); sclk = 1; clks(4); sclk = 0;
    end
    clks(6);
    chk(rx_empty == 1, "R10 edges ignored", 32'(rx_empty), 32'd1);

    // R2: three back-to-back bytes
    cfg(7, 1);
    xfer(64'h00a5_3cf0, 24);
    check_flags("R2");
    drain("R2");
    // R3: partial tail discarded
    xfer(64'h0000_0000_000b_e7d9, 20);
    check_flags("R3");
    drain("R3");
    // R2 full width
    cfg(31, 1);
    xfer(64'h1234_5678_9abc_def0, 64);
    drain("R2 wide");

    // R5 short burst, right aligned
    cfg(7, 0);
    xfer(64'h15, 5);
    check_flags("R5 short");
    drain("R5 short");
    // R5 zero bits: no commit
    xfer(64'h0, 0);
    chk(rx_empty == 1, "R5 empty select pulse", 32'(rx_empty), 32'd1);
    // R4 R6: 40 bits held, only last 8 kept
    xfer(64'h00c3_5a69_f00d_e1, 40);
    drain("R6");

    // R8: pop on empty ignored
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    xfer(64'h7e, 8);
    drain("R8 empty pop");

    // R9: overflow
    for (int i = 0; i < 9; i++) xfer(64'(8'h30 + i), 8);
    check_flags("R9 overflow");
    cfg(7, 0);
    chk(rx_ovf == 0 && rx_full == 1, "R9 ovf cleared by cfg", 32'({rx_ovf, rx_full}), 32'b01);
    drain("R9");

    // random
    for (int it = 0; it < 40; it++) begin
      int l, n;
      bit m;
      l = (it % 4 == 0) ? 31 : int'($urandom_range(0, 15));
      m = 1'($urandom_range(0, 1));
      n = int'($urandom_range(0, 48));
      cfg(l, m);
      xfer({$urandom(), $urandom()}, n);
      check_flags(m ? "R2 R3 random" : "R5 R6 random");
      drain("random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule